// File: doc/BRIEF.md
# Multi-Channel Latched Interrupt Aggregator

This block gathers event lines from several channels into sticky per-channel status registers. When an event line rises, the matching status bit is set, and it stays set until the processor reads that channel's status register. Reading the register returns the latched value and clears it. Two enables gate every status bit before it can request service. The first is a per-bit enable held in the channel's enable register. The second is a per-channel master enable.

The gated result of each channel becomes one bit of a read-only summary register, so the processor can tell at once which channels need attention. One shared interrupt request leaves the block in open-drain form. The block only ever asks the pad to pull the active-low line low, or lets it float, and it never drives the line high. A simple synchronous register port gives access to all registers. Read data is registered and is valid in the cycle after the read strobe.

Top module: `evt_irq_hub`

## Requirements
- R1: A rising edge on an event input sets its status bit at the next clock edge. An input that stays high sets the bit only once: once the bit is cleared, it stays clear until a new low-to-high transition arrives.
- R2: A status bit stays set until its channel's status register is read. That read returns the latched value and clears every bit of the register at the same edge.
- R3: If an event edge arrives in the same cycle as a clearing read of that register, the read returns the old value and the bit is left set.
- R4: The per-bit enable register of each channel can be written and read back in full. Bit 0 of the channel master enable register can be written and read back, and its other bits read as zero.
- R5: Summary bit c is 1 exactly when channel c's master enable is 1 and (status AND enable) of channel c is non-zero. Upper summary bits read as zero. Reading the summary register clears nothing, and writing it has no effect.
- R6: `irq_pull_low` is 1 in the cycle after any summary bit is 1, and 0 in the cycle after all summary bits are 0. A value of 1 means the pad pulls the shared active-low request line low; 0 means the line is released. The line is never driven high.
- R7: Writes to a status register have no effect on its contents.
- R8: Synchronous reset clears all status bits, all enables, the read data and `irq_pull_low`.
- R9: The address map places channel c at byte address 4c. Offset +0 is status (clear on read), +1 is the per-bit enable, and +2 is the master enable. The summary register sits at 4·NUM_CH (16 by default). Every other address reads as zero.
- R10: Read data appears on `cfg_rdata` in the cycle after `cfg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_CH*STAT_W | Event lines; channel c uses bits [c*STAT_W +: STAT_W] |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | ADDR_W | Register address (5 bits by default) |
| cfg_wdata | input | STAT_W | Write data |
| cfg_rdata | output | STAT_W | Registered read data |
| irq_pull_low | output | 1 | 1 = pad pulls the active-low request line low, 0 = released |

## Verification
The bench aims at four corner cases:
- **Read colliding with an event edge on the same bit.** A design that let the clear win would lose the event.
- **Event level held high across several reads.** A level-sensitive design would set the bit again after every clear.
- **Master enable off while enabled bits are pending.** A design that skipped the second gate would raise the request or show the channel in the summary.
- **Writes aimed at status and summary addresses, and reads of the summary.** A design that decoded these wrongly would corrupt latched events or clear them by accident.

Beyond these cases, random event toggling mixed with random register traffic is compared each cycle against a bench model of the request output and of every read value.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CHEN = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_chan_status.sv
module evt_chan_status #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic              wr_chen_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              chen_bit_i,
  input  logic              rd_clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o,
  output logic              chen_o
);
  logic [STAT_W-1:0] evt_q;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] enable_q;
  logic              chen_q;
  logic [STAT_W-1:0] rise;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] status_d;

  assign rise     = evt_i & ~evt_q;
  assign clr_vec  = {STAT_W{rd_clr_i}};
  assign status_d = (status_q & ~clr_vec) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q    <= '0;
      status_q <= '0;
      enable_q <= '0;
      chen_q   <= 1'b0;
    end else begin
      evt_q    <= evt_i;
      status_q <= status_d;
      if (wr_en_i)   enable_q <= wdata_i;
      if (wr_chen_i) chen_q   <= chen_bit_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign chen_o   = chen_q;

  // every detected edge is latched, even against a clear
  assert_edge_latched_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rise) & ~status_q) == '0));

  // set bits survive unless their register was read
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));

  // no bit appears without a fresh edge
  assert_no_retrigger_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((~$past(status_q) | $past(clr_vec)) & ~$past(rise) & status_q) == '0));

  assert_enable_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (enable_o == $past(wdata_i)));
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
  parameter int NUM_CH = 4,
  parameter int STAT_W = 8,
  localparam int FLAT_W = NUM_CH * STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAT_W-1:0] status_i,
  input  logic [FLAT_W-1:0] enable_i,
  input  logic [NUM_CH-1:0] chen_i,
  output logic [NUM_CH-1:0] summary_o,
  output logic              irq_pull_low_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
    assign summary_o[c] = chen_i[c] &
      (|(status_i[c*STAT_W +: STAT_W] & enable_i[c*STAT_W +: STAT_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) irq_pull_low_o <= 1'b0;
    else     irq_pull_low_o <= |summary_o;
  end

  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (summary_o != '0) |=> irq_pull_low_o);

  assert_irq_release_R6: assert property (@(posedge clk) disable iff (rst)
    (summary_o == '0) |=> !irq_pull_low_o);
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int STAT_W = 8,
  localparam int CH_IDX_W = $clog2(NUM_CH + 1),
  localparam int ADDR_W   = CH_IDX_W + 2,
  localparam int FLAT_W   = NUM_CH * STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAT_W-1:0] evt_in,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [STAT_W-1:0] cfg_wdata,
  output logic [STAT_W-1:0] cfg_rdata,
  output logic              irq_pull_low
);
  logic [CH_IDX_W-1:0] ch_idx;
  reg_sel_e            sel;
  logic [FLAT_W-1:0]   status_flat;
  logic [FLAT_W-1:0]   enable_flat;
  logic [NUM_CH-1:0]   chen_vec;
  logic [NUM_CH-1:0]   summary;
  logic [STAT_W-1:0]   rd_val;

  assign ch_idx = cfg_addr[ADDR_W-1:2];
  assign sel    = reg_sel_e'(cfg_addr[1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (ch_idx == CH_IDX_W'(c));

    evt_chan_status #(.STAT_W(STAT_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .evt_i      (evt_in[c*STAT_W +: STAT_W]),
      .wr_en_i    (cfg_wr && hit && sel == SEL_EN),
      .wr_chen_i  (cfg_wr && hit && sel == SEL_CHEN),
      .wdata_i    (cfg_wdata),
      .chen_bit_i (cfg_wdata[0]),
      .rd_clr_i   (cfg_rd && hit && sel == SEL_STAT),
      .status_o   (status_flat[c*STAT_W +: STAT_W]),
      .enable_o   (enable_flat[c*STAT_W +: STAT_W]),
      .chen_o     (chen_vec[c])
    );

    // a disabled channel never appears in the summary
    assert_summary_gate_R5: assert property (@(posedge clk) disable iff (rst)
      !chen_vec[c] |-> !summary[c]);
  end

  evt_irq_combine #(.NUM_CH(NUM_CH), .STAT_W(STAT_W)) u_comb (
    .clk            (clk),
    .rst            (rst),
    .status_i       (status_flat),
    .enable_i       (enable_flat),
    .chen_i         (chen_vec),
    .summary_o      (summary),
    .irq_pull_low_o (irq_pull_low)
  );

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CH_IDX_W'(c)) begin
        case (sel)
          SEL_STAT: rd_val = status_flat[c*STAT_W +: STAT_W];
          SEL_EN:   rd_val = enable_flat[c*STAT_W +: STAT_W];
          SEL_CHEN: rd_val = STAT_W'(chen_vec[c]);
          default:  rd_val = '0;
        endcase
      end
    end
    if (ch_idx == CH_IDX_W'(NUM_CH) && sel == SEL_STAT)
      rd_val = STAT_W'(summary);
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_val;
  end

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> $stable(cfg_rdata));
endmodule

// File: tb/sim_evt_irq_hub.sv
`timescale 1ns/1ps
module sim_evt_irq_hub;
  localparam int NC = 4;
  localparam int SW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_in = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        irq_pull_low;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;
  logic [3:0]  m_chen = '0;

  always #4 clk = ~clk;

  evt_irq_hub #(.NUM_CH(NC), .STAT_W(SW)) u0 (
    .clk(clk), .rst(rst), .evt_in(evt_in), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_pull_low(irq_pull_low));

  function automatic logic [3:0] m_sum();
    logic [3:0] s;
    for (int c = 0; c < NC; c++)
      s[c] = m_chen[c] & (|(m_stat[c*8 +: 8] & m_en[c*8 +: 8]));
    return s;
  endfunction

  function automatic logic [7:0] m_read(logic [4:0] a);
    int ch = int'(a[4:2]);
    if (ch < NC) begin
      case (a[1:0])
        2'd0: return m_stat[ch*8 +: 8];
        2'd1: return m_en[ch*8 +: 8];
        2'd2: return {7'b0, m_chen[ch]};
        default: return 8'h00;
      endcase
    end
    if (ch == NC && a[1:0] == 2'd0) return {4'b0, m_sum()};
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, logic [31:0] evt, logic wr, logic rd,
                      logic [4:0] a, logic [7:0] wd);
    logic [7:0]  exp_rd;
    logic        exp_irq;
    logic [31:0] rise;
    evt_in = evt; cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_wdata = wd;
    exp_rd  = m_read(a);
    exp_irq = |m_sum();
    @(posedge clk);
    rise = evt & ~m_prev;
    for (int c = 0; c < NC; c++) begin
      if (rd && a == 5'(c*4)) m_stat[c*8 +: 8] = 8'h00;
      if (wr && a == 5'(c*4+1)) m_en[c*8 +: 8] = wd;
      if (wr && a == 5'(c*4+2)) m_chen[c] = wd[0];
    end
    m_stat = m_stat | rise;
    m_prev = evt;
    @(negedge clk);
    chk("R6", 32'(irq_pull_low), 32'(exp_irq));
    if (rd) chk(req, 32'(cfg_rdata), 32'(exp_rd));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ev;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R8: registered outputs are clear while reset is held
    chk("R8", {31'b0, irq_pull_low}, 32'h0);
    chk("R8", 32'(cfg_rdata), 32'h0);
    rst = 1'b0;
    // R8 / R9: every address reads zero after reset
    for (int a = 0; a < 20; a++) step("R8", 32'h0, 1'b0, 1'b1, 5'(a), 8'h00);

    // R4: enables and master enables
    for (int c = 0; c < NC; c++) begin
      step("R4", 32'h0, 1'b1, 1'b0, 5'(c*4+1), 8'hFF);
      step("R4", 32'h0, 1'b1, 1'b0, 5'(c*4+2), 8'hFF);
      step("R4", 32'h0, 1'b0, 1'b1, 5'(c*4+2), 8'h00);
    end

    // R1: level held high latches only once
    ev = 32'h0000_0008;
    repeat (5) step("R1", ev, 1'b0, 1'b0, 5'd0, 8'h00);
    step("R1", ev, 1'b0, 1'b1, 5'd0, 8'h00);
    step("R1", ev, 1'b0, 1'b1, 5'd0, 8'h00);
    step("R2", ev, 1'b0, 1'b1, 5'd0, 8'h00);
    ev = 32'h0;
    step("R1", ev, 1'b0, 1'b0, 5'd0, 8'h00);

    // R3: edge colliding with the clearing read
    step("R3", 32'h0000_0400, 1'b0, 1'b0, 5'd4, 8'h00);
    step("R3", 32'h0, 1'b0, 1'b0, 5'd4, 8'h00);
    step("R3", 32'h0000_0400, 1'b0, 1'b1, 5'd4, 8'h00);
    step("R3", 32'h0000_0400, 1'b0, 1'b1, 5'd4, 8'h00);
    step("R2", 32'h0000_0400, 1'b0, 1'b1, 5'd4, 8'h00);

    // R7: writing a status register has no effect
    step("R7", 32'h0, 1'b0, 1'b0, 5'd0, 8'h00);
    step("R7", 32'h0000_0001, 1'b0, 1'b0, 5'd0, 8'h00);
    step("R7", 32'h0000_0001, 1'b1, 1'b0, 5'd0, 8'h00);
    step("R7", 32'h0000_0001, 1'b0, 1'b1, 5'd0, 8'h00);
    step("R7", 32'h0000_0001, 1'b1, 1'b0, 5'd8, 8'hFF);
    step("R7", 32'h0000_0001, 1'b0, 1'b1, 5'd8, 8'h00);

    // R5: master enable gates channel 2, summary read does not clear
    step("R5", 32'h0, 1'b1, 1'b0, 5'd10, 8'h00);
    step("R5", 32'h0001_0000, 1'b0, 1'b0, 5'd16, 8'h00);
    step("R5", 32'h0001_0000, 1'b0, 1'b1, 5'd16, 8'h00);
    step("R5", 32'h0001_0000, 1'b1, 1'b0, 5'd16, 8'hFF);
    step("R5", 32'h0001_0000, 1'b1, 1'b0, 5'd10, 8'h01);
    step("R5", 32'h0001_0000, 1'b0, 1'b1, 5'd16, 8'h00);
    step("R5", 32'h0001_0000, 1'b0, 1'b1, 5'd16, 8'h00);
    step("R5", 32'h0001_0000, 1'b0, 1'b1, 5'd8, 8'h00);
    step("R6", 32'h0001_0000, 1'b0, 1'b0, 5'd16, 8'h00);

    // random mix; R10 read data checked on every read
    ev = 32'h0001_0000;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] flip;
      int op;
      logic [4:0] ra;
      flip = $urandom & $urandom & $urandom & $urandom;
      ev = ev ^ flip;
      op = int'($urandom % 8);
      ra = 5'($urandom % 4) * 5'd4;
      case (op)
        0, 1: step("R2", ev, 1'b0, 1'b1, ra, 8'h00);
        2:    step("R5", ev, 1'b0, 1'b1, 5'd16, 8'h00);
        3:    step("R4", ev, 1'b1, 1'b0, ra + 5'd1, 8'($urandom));
        4:    step("R4", ev, 1'b1, 1'b0, ra + 5'd2, 8'($urandom));
        5:    step("R9", ev, 1'b0, 1'b1, 5'($urandom % 24), 8'h00);
        6:    step("R7", ev, 1'b1, 1'b0, 5'($urandom % 24), 8'($urandom));
        default: step("R10", ev, 1'b0, 1'b0, 5'd0, 8'h00);
      endcase
    end
    finish_run();
  end
endmodule